// File: doc/BRIEF.md
# Three-Wire Register-Mapped Command Slave

This block is the slave end of a serial control bus that has three wires: a clock (SCLK), an active-low select (SEN) and one shared data line (SDIO). All three are sampled by the chip's own system clock. A host starts a frame by pulling SEN low. It then shifts in a 9-bit control word made of a device code, a direction bit and a 5-bit register address. A 16-bit data word follows. On a write the host drives this word. On a read the slave drives it, after a half-cycle turnaround. A frame is only closed when SEN has returned high and SCLK has then made one full high-low pulse.

Behind the bus sits a small register map for a command engine. Three argument registers hold operand words. A command register launches a command on the core side each time it is written. Eight read-only response words come in from the core. The core sees the argument words and the latest command word, and gets a single-cycle issue strobe. The strobe is a plain pulse with no back-pressure: the core must accept it in any cycle. The response words are plain levels that the slave samples at the moment a read is decoded. SDIO is split into a data input, a data output and an output enable, which the pad ring combines.

Top module: `tw_cmd_slave`

## Requirements
- R1: After reset the output enable is low, the issue strobe is low, and the command word and all argument words are zero.
- R2: The first three control bits must equal 101 (first bit sent is 1). A frame with any other code changes no register, raises no strobe and never asserts the output enable.
- R3: A write to register 1, 2 or 3 stores the 16-bit word, received MSB first on SCLK rising edges, into argument word 0, 1 or 2. Argument word k sits on arg_o bits [16k+15:16k].
- R4: A write to register 0 loads the command word and raises cmd_issue_o for exactly one system clock. Each completed command write gives exactly one strobe.
- R5: On a read the slave starts driving SDIO at the SCLK falling edge that follows the ninth control bit, beginning with bit 15. It moves to the next lower bit on each later SCLK rising edge.
- R6: A read of register 0 returns the command word. Registers 1 to 3 return the argument words. Registers 8 to 15 return response words 0 to 7, where response word k is resp_i bits [16k+15:16k].
- R7: A read of any other register returns 0x0000. A write to registers 4 to 31 changes no register and raises no strobe.
- R8: A write takes effect only once SEN is high and SCLK has then pulsed high and low once. SCLK activity while no frame is open does not start a frame.
- R9: If SEN returns high before all 25 bits of a write have been clocked, nothing is stored and no strobe is raised.
- R10: The output enable drops once SEN returns high during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Bus clock from the host |
| sen_n_i | input | 1 | Frame select, active low |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Read data driven toward the pad |
| sdio_oe | output | 1 | High while the slave drives the data line |
| arg_o | output | 48 | Argument words; word k at bits [16k+15:16k] |
| cmd_word_o | output | 16 | Last command word written |
| cmd_issue_o | output | 1 | One-cycle pulse per completed command write |
| resp_i | input | 128 | Response words; word k at bits [16k+15:16k] |

## Verification
Writes are tried with alternating, single-bit and top-bit-only data words, so that a bit-order or shift-count error shows up as a wrong argument word. Reads of response words with distinct patterns at the first and last slot, and reads of the argument registers, separate an address decode error from a serialisation error. Frames with a wrong device code, frames cut short, writes to response and unmapped addresses, and SCLK toggling between frames all check that nothing is stored. The strobe is counted both before and after the closing pulse, which shows that commitment waits for that pulse.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam logic [2:0] DEV_CODE = 3'b101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_DECODE,
    ST_WDATA,
    ST_HOLD,
    ST_RWAIT,
    ST_RDATA,
    ST_CLOSE_RISE,
    ST_CLOSE_FALL
  } frame_st_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d_i;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sen_n_s,
  input  logic              sdio_s,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic              sdio_o,
  output logic              sdio_oe
);
  localparam int CW    = 3 + 1 + ADDR_W;
  localparam int MAXB  = (DATA_W > CW) ? DATA_W : CW;
  localparam int CNT_W = $clog2(MAXB);

  frame_st_e         st;
  logic              sclk_d;
  logic              sclk_rise, sclk_fall;
  logic [CW-1:0]     ctrl_sr;
  logic [DATA_W-1:0] wr_sr;
  logic [DATA_W-1:0] rd_sr;
  logic [CNT_W-1:0]  cnt;
  logic              ok;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  assign addr_o    = ctrl_sr[ADDR_W-1:0];
  assign wr_data_o = wr_sr;
  assign sdio_o    = rd_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sclk_d   <= 1'b0;
      ctrl_sr  <= '0;
      wr_sr    <= '0;
      rd_sr    <= '0;
      cnt      <= '0;
      ok       <= 1'b0;
      commit_o <= 1'b0;
      sdio_oe  <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      commit_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (!sen_n_s) begin
            st  <= ST_CTRL;
            cnt <= '0;
            ok  <= 1'b0;
          end
        end
        ST_CTRL: begin
          if (sen_n_s) begin
            st <= ST_CLOSE_RISE;
          end else if (sclk_rise) begin
            ctrl_sr <= {ctrl_sr[CW-2:0], sdio_s};
            cnt     <= cnt + 1'b1;
            if (cnt == CNT_W'(CW-1)) st <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          cnt <= '0;
          if (ctrl_sr[CW-1 -: 3] != DEV_CODE) begin
            st <= ST_HOLD;
          end else if (ctrl_sr[ADDR_W]) begin
            rd_sr <= rd_word_i;
            st    <= ST_RWAIT;
          end else begin
            st <= ST_WDATA;
          end
        end
        ST_WDATA: begin
          if (sen_n_s) begin
            st <= ST_CLOSE_RISE;
          end else if (sclk_rise) begin
            wr_sr <= {wr_sr[DATA_W-2:0], sdio_s};
            cnt   <= cnt + 1'b1;
            if (cnt == CNT_W'(DATA_W-1)) begin
              ok <= 1'b1;
              st <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (sen_n_s) st <= ST_CLOSE_RISE;
        end
        ST_RWAIT: begin
          if (sen_n_s) begin
            st <= ST_CLOSE_RISE;
          end else if (sclk_fall) begin
            sdio_oe <= 1'b1;
            st      <= ST_RDATA;
          end
        end
        ST_RDATA: begin
          if (sen_n_s) begin
            sdio_oe <= 1'b0;
            st      <= ST_CLOSE_RISE;
          end else if (sclk_rise && cnt != CNT_W'(DATA_W-1)) begin
            rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
          end
        end
        ST_CLOSE_RISE: begin
          if (sen_n_s && sclk_rise) st <= ST_CLOSE_FALL;
        end
        ST_CLOSE_FALL: begin
          if (sclk_fall) begin
            commit_o <= ok;
            ok       <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: data line released once select returns high
  assert_release_on_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sen_n_s) |=> !sdio_oe);

  // R8: a commit only happens while select is high
  assert_commit_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> sen_n_s);

  // R2: a frame parked without a good write never drives the line
  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && !ok) |-> !sdio_oe);

  // R5: driving starts right after an SCLK falling edge
  assert_turnaround_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(sclk_fall));
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int N_ARG     = 3,
  parameter int N_RESP    = 8,
  parameter int CMD_ADDR  = 0,
  parameter int ARG_BASE  = 1,
  parameter int RESP_BASE = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [N_RESP*DATA_W-1:0] resp_i,
  output logic [DATA_W-1:0]        rd_word_o,
  output logic [N_ARG*DATA_W-1:0]  arg_o,
  output logic [DATA_W-1:0]        cmd_word_o,
  output logic                     cmd_issue_o
);
  localparam int ARG_LAST = ARG_BASE + N_ARG - 1;

  generate
    for (genvar g = 0; g < N_ARG; g++) begin : g_arg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arg_o[g*DATA_W +: DATA_W] <= '0;
        else if (commit_i && addr_i == ADDR_W'(ARG_BASE + g))
          arg_o[g*DATA_W +: DATA_W] <= wr_data_i;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word_o  <= '0;
      cmd_issue_o <= 1'b0;
    end else begin
      cmd_issue_o <= 1'b0;
      if (commit_i && addr_i == ADDR_W'(CMD_ADDR)) begin
        cmd_word_o  <= wr_data_i;
        cmd_issue_o <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_word_o = '0;
    if (addr_i == ADDR_W'(CMD_ADDR)) rd_word_o = cmd_word_o;
    for (int a = 0; a < N_ARG; a++)
      if (addr_i == ADDR_W'(ARG_BASE + a)) rd_word_o = arg_o[a*DATA_W +: DATA_W];
    for (int r = 0; r < N_RESP; r++)
      if (addr_i == ADDR_W'(RESP_BASE + r)) rd_word_o = resp_i[r*DATA_W +: DATA_W];
  end

  // R4: the issue strobe never lasts longer than one cycle
  assert_strobe_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue_o |=> !cmd_issue_o);

  // R4: a strobe always follows a frame commit
  assert_strobe_after_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue_o |-> $past(commit_i));

  // R7: commits above the writable range leave everything alone
  assert_drop_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && addr_i > ADDR_W'(ARG_LAST)) |=> ($stable(arg_o) && !cmd_issue_o));
endmodule

// File: rtl/tw_cmd_slave.sv
module tw_cmd_slave
  import tw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int N_ARG       = 3,
  parameter int N_RESP      = 8,
  parameter int CMD_ADDR    = 0,
  parameter int ARG_BASE    = 1,
  parameter int RESP_BASE   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_i,
  input  logic                     sen_n_i,
  input  logic                     sdio_i,
  output logic                     sdio_o,
  output logic                     sdio_oe,
  output logic [N_ARG*DATA_W-1:0]  arg_o,
  output logic [DATA_W-1:0]        cmd_word_o,
  output logic                     cmd_issue_o,
  input  logic [N_RESP*DATA_W-1:0] resp_i
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_word;
  logic              commit;

  tw_sync #(
    .N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sdio_i, sen_n_i, sclk_i}),
    .q_o   (pins_s)
  );

  tw_frame #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[0]),
    .sen_n_s   (pins_s[1]),
    .sdio_s    (pins_s[2]),
    .rd_word_i (rd_word),
    .addr_o    (addr),
    .wr_data_o (wr_data),
    .commit_o  (commit),
    .sdio_o    (sdio_o),
    .sdio_oe   (sdio_oe)
  );

  tw_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_ARG(N_ARG), .N_RESP(N_RESP),
    .CMD_ADDR(CMD_ADDR), .ARG_BASE(ARG_BASE), .RESP_BASE(RESP_BASE)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_i    (commit),
    .addr_i      (addr),
    .wr_data_i   (wr_data),
    .resp_i      (resp_i),
    .rd_word_o   (rd_word),
    .arg_o       (arg_o),
    .cmd_word_o  (cmd_word_o),
    .cmd_issue_o (cmd_issue_o)
  );
endmodule

// File: tb/tb_tw_cmd_slave.sv
module tb_tw_cmd_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sen_n = 1'b1, sdio_h = 1'b0;
  logic sdio_o, sdio_oe, cmd_issue_o;
  logic [47:0]  arg_o;
  logic [15:0]  cmd_word_o;
  logic [127:0] resp_bus;

  int checks = 0, fails = 0, issue_cnt = 0;
  logic prev_issue = 1'b0;
  logic [15:0] exp_q[$];
  logic [15:0] exp_arg[3];
  logic [15:0] exp_cmd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_cmd_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sen_n_i(sen_n), .sdio_i(sdio_h),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .arg_o(arg_o), .cmd_word_o(cmd_word_o),
    .cmd_issue_o(cmd_issue_o), .resp_i(resp_bus)
  );

  function automatic logic [15:0] resp_pat(int k);
    return 16'h1357 * 16'(k + 1) ^ 16'hC3A5;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for issued commands
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_issue_o) begin
        issue_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected strobe", 32'(cmd_word_o), 32'h0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(cmd_word_o == e, "R4 issued command word", 32'(cmd_word_o), 32'(e));
        end
        if (prev_issue) chk(1'b0, "R4 strobe wider than one cycle", 32'd2, 32'd1);
      end
      prev_issue = cmd_issue_o;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sdio_h = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_ctrl(input logic [2:0] code, input logic rw, input logic [4:0] addr);
    logic [8:0] w;
    w = {code, rw, addr};
    for (int i = 8; i >= 0; i--) bit_out(w[i]);
  endtask

  task automatic close_pulse;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
    wait_clk(2*HALF);
  endtask

  task automatic wr_frame(input logic [2:0] code, input logic [4:0] addr,
                          input logic [15:0] data, input int nbits);
    int cnt0;
    bit good;
    good = (code == 3'b101) && (nbits == 16);
    if (good && addr >= 1 && addr <= 3) exp_arg[addr-1] = data;
    if (good && addr == 0) begin
      exp_q.push_back(data);
      exp_cmd = data;
    end
    cnt0 = issue_cnt;
    sen_n = 1'b0;
    wait_clk(HALF);
    send_ctrl(code, 1'b0, addr);
    for (int i = 15; i >= 16 - nbits; i--) bit_out(data[i]);
    wait_clk(HALF);
    sen_n = 1'b1;
    wait_clk(3*HALF);
    chk(issue_cnt == cnt0, "R8 no strobe before closing pulse", 32'(issue_cnt), 32'(cnt0));
    close_pulse();
    chk(issue_cnt == cnt0 + ((good && addr == 0) ? 1 : 0), "R4/R9 strobe count after close",
        32'(issue_cnt), 32'(cnt0 + ((good && addr == 0) ? 1 : 0)));
  endtask

  task automatic rd_frame(input logic [2:0] code, input logic [4:0] addr,
                          output logic [15:0] got, output bit drove, output bit all_on);
    got = '0;
    drove = 1'b0;
    all_on = 1'b1;
    sen_n = 1'b0;
    wait_clk(HALF);
    send_ctrl(code, 1'b1, addr);
    chk(sdio_oe == 1'b0, "R5 line free before turnaround", 32'(sdio_oe), 32'h0);
    for (int i = 15; i >= 0; i--) begin
      wait_clk(HALF - 1);
      got[i] = sdio_oe ? sdio_o : 1'b0;
      drove |= sdio_oe;
      all_on &= sdio_oe;
      wait_clk(1);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    sen_n = 1'b1;
    wait_clk(HALF);
    chk(sdio_oe == 1'b0, "R10 released after deselect", 32'(sdio_oe), 32'h0);
    close_pulse();
  endtask

  task automatic chk_regs(input string req);
    for (int k = 0; k < 3; k++)
      chk(arg_o[k*16 +: 16] == exp_arg[k], req, 32'(arg_o[k*16 +: 16]), 32'(exp_arg[k]));
    chk(cmd_word_o == exp_cmd, req, 32'(cmd_word_o), 32'(exp_cmd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] got;
    bit drove, all_on;
    for (int k = 0; k < 8; k++) resp_bus[k*16 +: 16] = resp_pat(k);
    for (int k = 0; k < 3; k++) exp_arg[k] = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);

    // R1 reset state
    chk(sdio_oe == 1'b0, "R1 oe at reset", 32'(sdio_oe), 32'h0);
    chk(cmd_issue_o == 1'b0, "R1 strobe at reset", 32'(cmd_issue_o), 32'h0);
    chk_regs("R1 registers at reset");

    // R3 argument writes with distinct bit patterns
    wr_frame(3'b101, 5'd1, 16'hA5C3, 16);
    wr_frame(3'b101, 5'd2, 16'h0001, 16);
    wr_frame(3'b101, 5'd3, 16'h8000, 16);
    chk_regs("R3 argument words");

    // R4 command writes, back to back
    wr_frame(3'b101, 5'd0, 16'h1234, 16);
    chk_regs("R4 command word");
    wr_frame(3'b101, 5'd0, 16'hFFFF, 16);
    chk_regs("R4 second command word");

    // R5/R6 reads of responses, arguments, command
    rd_frame(3'b101, 5'd8, got, drove, all_on);
    chk(all_on, "R5 driven for all 16 bits", 32'(all_on), 32'h1);
    chk(got == resp_pat(0), "R6 response word 0", 32'(got), 32'(resp_pat(0)));
    rd_frame(3'b101, 5'd15, got, drove, all_on);
    chk(got == resp_pat(7), "R6 response word 7", 32'(got), 32'(resp_pat(7)));
    rd_frame(3'b101, 5'd2, got, drove, all_on);
    chk(got == exp_arg[1], "R6 argument readback", 32'(got), 32'(exp_arg[1]));
    rd_frame(3'b101, 5'd0, got, drove, all_on);
    chk(got == exp_cmd, "R6 command readback", 32'(got), 32'(exp_cmd));

    // R7 unmapped reads and dropped writes
    rd_frame(3'b101, 5'd5, got, drove, all_on);
    chk(got == 16'h0000 && all_on, "R7 unmapped read", 32'(got), 32'h0);
    wr_frame(3'b101, 5'd9, 16'hDEAD, 16);
    wr_frame(3'b101, 5'd20, 16'hBEEF, 16);
    chk_regs("R7 writes dropped");

    // R2 wrong device code, write then read
    wr_frame(3'b110, 5'd1, 16'h7777, 16);
    wr_frame(3'b001, 5'd0, 16'h4242, 16);
    chk_regs("R2 bad code write ignored");
    rd_frame(3'b100, 5'd8, got, drove, all_on);
    chk(drove == 1'b0, "R2 bad code read never drives", 32'(drove), 32'h0);

    // R9 frames cut short
    wr_frame(3'b101, 5'd3, 16'h5A5A, 8);
    wr_frame(3'b101, 5'd0, 16'h9999, 15);
    chk_regs("R9 aborted writes");

    // R8 SCLK activity with no frame open
    for (int i = 0; i < 12; i++) bit_out(1'b0);
    chk(issue_cnt == 2, "R8 idle clocks start nothing", 32'(issue_cnt), 32'd2);
    wr_frame(3'b101, 5'd1, 16'h0F0F, 16);
    chk_regs("R8 frame after idle clocks");

    wait_clk(10);
    chk(exp_q.size() == 0, "R4 all commands issued", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule